// File: doc/BRIEF.md
# Converter Low-Power Mode Sequencer

This block sits on the host side of a three-wire serial sampling converter. It moves the converter into its low-power states and back out again. It uses only the converter's active-low select line and its serial clock line, and holds no data path of its own. To reach the light power-down state (nap), it sends two select pulses. To reach the deep one (sleep), it sends four. Throughout either burst the serial clock is frozen at a rest level chosen by a parameter.

A wake request produces a single serial-clock pulse. The block then holds the converter back from conversion for a recovery interval, and that interval depends on which state is being left. Leaving nap needs only a few system clocks. Leaving sleep needs a much longer wait, counted in system clocks from the clock frequency and the recovery time given in microseconds.

The two wires are shared with a readout controller. The readout controller drives them through this block only while the grant output is high, which is exactly when the converter is active and no sequence is running. A request that cannot be honoured produces a one-cycle error pulse and changes nothing. This covers a request during a running sequence, a request that makes no sense in the present mode, or several requests at once.

Top module: `cnv_pwr_seq`

## Requirements
- R1: After reset, mode reads 0 (active), ready and rdGrant are 1 and reqErr is 0.
- R2: The mode output encodes 0 = active, 1 = nap, 2 = sleep, 3 = recovering; ready is 1 only while mode is 0 and no sequence runs, and rdGrant equals ready.
- R3: A lone reqNap accepted in active mode drives csN low for exactly CS_LOW_CYC cycles, twice, each low followed by CS_HIGH_CYC high cycles. Mode reads 1 on the 2*(CS_LOW_CYC+CS_HIGH_CYC)+1-th sample after the request edge.
- R4: A lone reqSleep accepted in active mode sends four such pulses, and mode reads 2 on the 4*(CS_LOW_CYC+CS_HIGH_CYC)+1-th sample after the request edge.
- R5: While select pulses are sent, and while the converter rests in nap or sleep, sck stays at SCK_REST.
- R6: A lone reqWake accepted in nap or sleep sets mode to 3 and drives sck to the level opposite SCK_REST exactly once, for SCK_PULSE_CYC cycles, while csN stays high.
- R7: When waking from nap, mode returns to 0 and ready rises on the SCK_PULSE_CYC+ceil(CLK_MHZ*NAP_WAIT_NS/1000)+1-th sample after the request edge.
- R8: When waking from sleep, mode returns to 0 and ready rises on the SCK_PULSE_CYC+CLK_MHZ*SLEEP_WAIT_US+1-th sample after the request edge.
- R9: Any request that arrives while a sequence is running raises reqErr for one cycle, in the cycle after the request. The running sequence continues unchanged.
- R10: In a resting mode, any request combination other than the single accepted one raises reqErr for one cycle and leaves mode unchanged. In active mode the accepted ones are a lone nap or a lone sleep request; in nap or sleep the accepted one is a lone wake request.
- R11: While ready is 1, csN and sck follow rdCsN and rdSck. Otherwise rdCsN and rdSck are ignored, and outside a sequence csN is held high and sck at SCK_REST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqNap | input | 1 | Request entry into nap |
| reqSleep | input | 1 | Request entry into sleep |
| reqWake | input | 1 | Request wake-up from nap or sleep |
| rdCsN | input | 1 | Select line from the readout controller |
| rdSck | input | 1 | Serial clock from the readout controller |
| csN | output | 1 | Active-low select line to the converter |
| sck | output | 1 | Serial clock line to the converter |
| mode | output | 2 | Current power mode (0 active, 1 nap, 2 sleep, 3 recovering) |
| ready | output | 1 | Converter may start a conversion |
| rdGrant | output | 1 | Readout controller owns the wires |
| reqErr | output | 1 | One-cycle pulse on a refused request |

## Verification
Two functions can coincide in one cycle: a sequence step that is in progress, and the refusal of a new request. The bench injects a wake request in the third cycle of every select-pulse burst, and a nap request during every wake recovery. It expects an error pulse in the next cycle, and it expects the burst's pulse count, pulse widths and completion latency to be exactly what they would be without the injection. The second overlap is between readout wire inputs that toggle while the sequencer owns the wires. This is judged by checking that csN and sck stay at their rest values in nap and sleep.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE  = 2'd0,
    MODE_NAP     = 2'd1,
    MODE_SLEEP   = 2'd2,
    MODE_RECOVER = 2'd3
  } pwrMode_e;

  typedef enum logic [1:0] {
    TMR_CSLOW  = 2'd0,
    TMR_CSHIGH = 2'd1,
    TMR_SCK    = 2'd2,
    TMR_REC    = 2'd3
  } tmrSel_e;

  // select pulses required by the converter protocol
  localparam int NAP_PULSES   = 2;
  localparam int SLEEP_PULSES = 4;

  typedef struct packed {
    logic    tmrLoad;
    tmrSel_e tmrSel;
    logic    recSleep;
    logic    pulseClr;
    logic    pulseInc;
    logic    csAssert;
    logic    sckAssert;
  } seqStrobe_t;

endpackage

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int   CS_LOW_CYC    = 2,
  parameter int   CS_HIGH_CYC   = 2,
  parameter int   SCK_PULSE_CYC = 1,
  parameter int   NAP_REC_CYC   = 3,
  parameter int   SLEEP_REC_CYC = 55000,
  parameter logic SCK_REST      = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       tmrDone,
  output logic [2:0] pulseCnt,
  output logic       seqCsN,
  output logic       seqSck
);

  localparam int MAX_A  = (CS_LOW_CYC > CS_HIGH_CYC) ? CS_LOW_CYC : CS_HIGH_CYC;
  localparam int MAX_B  = (MAX_A > SCK_PULSE_CYC) ? MAX_A : SCK_PULSE_CYC;
  localparam int MAX_C  = (MAX_B > NAP_REC_CYC) ? MAX_B : NAP_REC_CYC;
  localparam int MAXLEN = (MAX_C > SLEEP_REC_CYC) ? MAX_C : SLEEP_REC_CYC;
  localparam int TW     = $clog2(MAXLEN + 1);

  logic [TW-1:0] tmr;
  logic [TW-1:0] loadVal;

  always_comb begin
    case (strobe.tmrSel)
      TMR_CSLOW:  loadVal = TW'(CS_LOW_CYC - 1);
      TMR_CSHIGH: loadVal = TW'(CS_HIGH_CYC - 1);
      TMR_SCK:    loadVal = TW'(SCK_PULSE_CYC - 1);
      default:    loadVal = strobe.recSleep ? TW'(SLEEP_REC_CYC - 1) : TW'(NAP_REC_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr      <= '0;
      pulseCnt <= '0;
      seqCsN   <= 1'b1;
      seqSck   <= SCK_REST;
    end else begin
      if (strobe.tmrLoad)  tmr <= loadVal;
      else if (tmr != '0)  tmr <= tmr - 1'b1;
      if (strobe.pulseClr)      pulseCnt <= '0;
      else if (strobe.pulseInc) pulseCnt <= pulseCnt + 1'b1;
      seqCsN <= !strobe.csAssert;
      seqSck <= SCK_REST ^ strobe.sckAssert;
    end
  end

  assign tmrDone = (tmr == '0);

  // R5: select pulse and clock pulse never overlap
  a_r5_cs_excl_sck: assert property (@(posedge clk) disable iff (!rstN)
    !seqCsN |-> (seqSck == SCK_REST));

  // R6: a clock pulse is never driven with the select line low
  a_r6_sck_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    (seqSck != SCK_REST) |-> seqCsN);

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqNap,
  input  logic       reqSleep,
  input  logic       reqWake,
  input  logic       tmrDone,
  input  logic [2:0] pulseCnt,
  output seqStrobe_t strobe,
  output pwrMode_e   mode,
  output logic       ready,
  output logic       reqErr
);

  typedef enum logic [2:0] {S_IDLE, S_CSLOW, S_CSHIGH, S_SCKP, S_WAIT} seqState_e;

  seqState_e state, stateNext;
  pwrMode_e  modeNext;
  logic      tgtSleep, tgtSleepNext;
  logic      fromSleep, fromSleepNext;
  logic      anyReq, accEnter, accWake, idle;
  logic [2:0] pulseGoal;

  assign anyReq    = reqNap | reqSleep | reqWake;
  assign idle      = (state == S_IDLE);
  assign accEnter  = idle && (mode == MODE_ACTIVE) && !reqWake && (reqNap ^ reqSleep);
  assign accWake   = idle && ((mode == MODE_NAP) || (mode == MODE_SLEEP))
                     && reqWake && !reqNap && !reqSleep;
  assign pulseGoal = tgtSleep ? 3'(SLEEP_PULSES) : 3'(NAP_PULSES);

  always_comb begin
    stateNext     = state;
    modeNext      = mode;
    tgtSleepNext  = tgtSleep;
    fromSleepNext = fromSleep;
    strobe        = '0;
    strobe.tmrSel = TMR_CSLOW;
    case (state)
      S_IDLE: begin
        if (accEnter) begin
          stateNext       = S_CSLOW;
          tgtSleepNext    = reqSleep;
          strobe.tmrLoad  = 1'b1;
          strobe.tmrSel   = TMR_CSLOW;
          strobe.pulseClr = 1'b1;
          strobe.csAssert = 1'b1;
        end else if (accWake) begin
          stateNext        = S_SCKP;
          modeNext         = MODE_RECOVER;
          fromSleepNext    = (mode == MODE_SLEEP);
          strobe.tmrLoad   = 1'b1;
          strobe.tmrSel    = TMR_SCK;
          strobe.sckAssert = 1'b1;
        end
      end
      S_CSLOW: begin
        if (tmrDone) begin
          stateNext       = S_CSHIGH;
          strobe.tmrLoad  = 1'b1;
          strobe.tmrSel   = TMR_CSHIGH;
          strobe.pulseInc = 1'b1;
        end else begin
          strobe.csAssert = 1'b1;
        end
      end
      S_CSHIGH: begin
        if (tmrDone) begin
          if (pulseCnt == pulseGoal) begin
            stateNext = S_IDLE;
            modeNext  = tgtSleep ? MODE_SLEEP : MODE_NAP;
          end else begin
            stateNext       = S_CSLOW;
            strobe.tmrLoad  = 1'b1;
            strobe.tmrSel   = TMR_CSLOW;
            strobe.csAssert = 1'b1;
          end
        end
      end
      S_SCKP: begin
        if (tmrDone) begin
          stateNext       = S_WAIT;
          strobe.tmrLoad  = 1'b1;
          strobe.tmrSel   = TMR_REC;
          strobe.recSleep = fromSleep;
        end else begin
          strobe.sckAssert = 1'b1;
        end
      end
      S_WAIT: begin
        if (tmrDone) begin
          stateNext = S_IDLE;
          modeNext  = MODE_ACTIVE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      mode      <= MODE_ACTIVE;
      tgtSleep  <= 1'b0;
      fromSleep <= 1'b0;
      ready     <= 1'b1;
      reqErr    <= 1'b0;
    end else begin
      state     <= stateNext;
      mode      <= modeNext;
      tgtSleep  <= tgtSleepNext;
      fromSleep <= fromSleepNext;
      ready     <= (stateNext == S_IDLE) && (modeNext == MODE_ACTIVE);
      reqErr    <= anyReq && !(accEnter || accWake);
    end
  end

  // R2: ready implies active mode
  a_r2_ready_active: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (mode == MODE_ACTIVE));

  // R9: a request during a running sequence is refused
  a_r9_busy_refuse: assert property (@(posedge clk) disable iff (!rstN)
    ((state != S_IDLE) && anyReq) |=> reqErr);

  // R3: mode is held while a select pulse is low
  a_r3_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CSLOW) |=> $stable(mode));

  // R6: the recovery wait always reports recovering
  a_r6_wait_recover: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> (mode == MODE_RECOVER));

endmodule

// File: rtl/cnv_pwr_seq.sv
module cnv_pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int   CLK_MHZ       = 50,
  parameter int   CS_LOW_CYC    = 2,
  parameter int   CS_HIGH_CYC   = 2,
  parameter int   SCK_PULSE_CYC = 1,
  parameter int   NAP_WAIT_NS   = 50,
  parameter int   SLEEP_WAIT_US = 1100,
  parameter logic SCK_REST      = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqNap,
  input  logic       reqSleep,
  input  logic       reqWake,
  input  logic       rdCsN,
  input  logic       rdSck,
  output logic       csN,
  output logic       sck,
  output logic [1:0] mode,
  output logic       ready,
  output logic       rdGrant,
  output logic       reqErr
);

  localparam int NAP_RAW       = (CLK_MHZ * NAP_WAIT_NS + 999) / 1000;
  localparam int NAP_REC_CYC   = (NAP_RAW < 1) ? 1 : NAP_RAW;
  localparam int SLEEP_RAW     = CLK_MHZ * SLEEP_WAIT_US;
  localparam int SLEEP_REC_CYC = (SLEEP_RAW < 1) ? 1 : SLEEP_RAW;

  seqStrobe_t strobe;
  pwrMode_e   modeQ;
  logic       tmrDone;
  logic [2:0] pulseCnt;
  logic       seqCsN, seqSck;

  pwrseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqNap(reqNap), .reqSleep(reqSleep), .reqWake(reqWake),
    .tmrDone(tmrDone), .pulseCnt(pulseCnt),
    .strobe(strobe), .mode(modeQ), .ready(ready), .reqErr(reqErr)
  );

  pwrseq_dp #(
    .CS_LOW_CYC(CS_LOW_CYC), .CS_HIGH_CYC(CS_HIGH_CYC),
    .SCK_PULSE_CYC(SCK_PULSE_CYC), .NAP_REC_CYC(NAP_REC_CYC),
    .SLEEP_REC_CYC(SLEEP_REC_CYC), .SCK_REST(SCK_REST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tmrDone(tmrDone), .pulseCnt(pulseCnt),
    .seqCsN(seqCsN), .seqSck(seqSck)
  );

  assign mode    = modeQ;
  assign rdGrant = ready;
  assign csN     = ready ? rdCsN : seqCsN;
  assign sck     = ready ? rdSck : seqSck;

endmodule

// File: tb/cnv_pwr_seq_bench.sv
module cnv_pwr_seq_bench;

  localparam int   CSL  = 2;
  localparam int   CSH  = 3;
  localparam int   SCKP = 2;
  localparam int   MHZ  = 50;
  localparam int   NAPNS = 50;
  localparam int   SLPUS = 2;
  localparam logic REST = 1'b1;
  localparam int   NAPW = (MHZ * NAPNS + 999) / 1000;
  localparam int   SLPW = MHZ * SLPUS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqNap = 0, reqSleep = 0, reqWake = 0;
  logic rdCsN = 1'b1, rdSck = REST;
  logic csN, sck, ready, rdGrant, reqErr;
  logic [1:0] mode;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cnv_pwr_seq #(
    .CLK_MHZ(MHZ), .CS_LOW_CYC(CSL), .CS_HIGH_CYC(CSH), .SCK_PULSE_CYC(SCKP),
    .NAP_WAIT_NS(NAPNS), .SLEEP_WAIT_US(SLPUS), .SCK_REST(REST)
  ) u_cnv_pwr_seq (
    .clk(clk), .rstN(rstN), .reqNap(reqNap), .reqSleep(reqSleep), .reqWake(reqWake),
    .rdCsN(rdCsN), .rdSck(rdSck), .csN(csN), .sck(sck), .mode(mode),
    .ready(ready), .rdGrant(rdGrant), .reqErr(reqErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enter(input bit toSleep);
    int lat, falls, lowRun, highRun, badW, sckMoved, npulse, tgt;
    bit prevCs;
    npulse = toSleep ? 4 : 2;
    tgt = toSleep ? 2 : 1;
    @(negedge clk); reqNap = !toSleep; reqSleep = toSleep;
    @(negedge clk); reqNap = 0; reqSleep = 0;
    lat = 1; falls = 0; lowRun = 0; highRun = 0; badW = 0; sckMoved = 0; prevCs = 1;
    while (mode != 2'(tgt) && lat < 1000) begin
      check(ready == 0 && rdGrant == 0, "R2", ready, 0);
      if (prevCs && !csN) begin
        if (falls > 0 && highRun != CSH) badW++;
        falls++; highRun = 0;
      end
      if (!csN) lowRun++;
      else begin
        if (lowRun != 0 && lowRun != CSL) badW++;
        lowRun = 0;
        if (falls > 0) highRun++;
      end
      if (sck != REST) sckMoved++;
      prevCs = csN;
      if (lat == 3) begin reqWake = 1; rdSck = !REST; rdCsN = 0; end
      @(negedge clk); lat++;
      if (lat == 4) begin
        reqWake = 0;
        check(reqErr == 1, "R9", reqErr, 1);
      end
    end
    check(falls == npulse, toSleep ? "R4" : "R3", falls, npulse);
    check(badW == 0 && highRun == CSH, toSleep ? "R4" : "R3", badW, 0);
    check(lat == npulse * (CSL + CSH) + 1, toSleep ? "R4" : "R3", lat, npulse * (CSL + CSH) + 1);
    check(sckMoved == 0, "R5", sckMoved, 0);
    check(ready == 0 && rdGrant == 0 && mode == 2'(tgt), "R2", mode, tgt);
    // R11: readout inputs ignored while resting low-power
    repeat (3) begin
      @(negedge clk); rdSck = ~rdSck;
      check(csN == 1 && sck == REST, "R11", {csN, sck}, {1'b1, REST});
    end
    rdCsN = 1; rdSck = REST;
  endtask

  task automatic wake(input bit fromSleep);
    int lat, pulseS, starts, csLow, badMode, w;
    bit prevAct;
    w = fromSleep ? SLPW : NAPW;
    @(negedge clk); reqWake = 1;
    @(negedge clk); reqWake = 0;
    lat = 1; pulseS = 0; starts = 0; csLow = 0; badMode = 0; prevAct = 0;
    while (mode != 2'd0 && lat < 1000) begin
      if (mode != 2'd3 || ready) badMode++;
      if (sck != REST) begin pulseS++; if (!prevAct) starts++; end
      prevAct = (sck != REST);
      if (!csN) csLow++;
      if (lat == 2) reqNap = 1;
      @(negedge clk); lat++;
      if (lat == 3) begin
        reqNap = 0;
        check(reqErr == 1, "R9", reqErr, 1);
      end
    end
    check(badMode == 0, "R6", badMode, 0);
    check(starts == 1 && pulseS == SCKP, "R6", pulseS, SCKP);
    check(csLow == 0, "R6", csLow, 0);
    check(lat == SCKP + w + 1, fromSleep ? "R8" : "R7", lat, SCKP + w + 1);
    check(ready == 1 && rdGrant == 1, fromSleep ? "R8" : "R7", ready, 1);
  endtask

  task automatic refuse(input int code, input int m);
    @(negedge clk); reqNap = code[0]; reqSleep = code[1]; reqWake = code[2];
    @(negedge clk); reqNap = 0; reqSleep = 0; reqWake = 0;
    check(reqErr == 1, "R10", reqErr, 1);
    check(mode == 2'(m), "R10", mode, m);
    @(negedge clk);
    check(reqErr == 0 && mode == 2'(m), "R10", reqErr, 0);
  endtask

  task automatic restSweep(input int m);
    for (int c = 1; c < 8; c++) if (c != 4) refuse(c, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(mode == 0 && ready == 1 && rdGrant == 1 && reqErr == 0, "R1", mode, 0);
    // R11 passthrough when granted
    for (int p = 0; p < 4; p++) begin
      rdCsN = p[0]; rdSck = p[1];
      #1 check(csN == p[0] && sck == p[1], "R11", {csN, sck}, p[1:0]);
    end
    @(negedge clk); rdCsN = 1; rdSck = REST;
    // sweep all request codes in active mode
    for (int c = 1; c < 8; c++) begin
      if (c == 1) begin enter(0); restSweep(1); wake(0); end
      else if (c == 2) begin enter(1); restSweep(2); wake(1); end
      else refuse(c, 0);
    end
    // back-to-back cycles, second pass
    enter(1); wake(1);
    enter(0); wake(0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule